// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block is the digital front end of a four-channel, 8-bit voltage DAC. A host writes 12-bit command words over a three-wire serial port: data, a serial clock and an active-low select. Each word carries two active-low shutdown controls, a two-bit channel address and a data byte. When the select line rises, the data byte goes into the staging register of the addressed channel. The shutdown flags are updated at the same moment.

The staging registers form the first of two buffer stages. A level-sensitive, active-low load input copies all four staging registers into the output code registers at once. A host can therefore preload every channel and then change all four outputs together. An active-low clear input and the power-on reset both return every register to zero scale and release all shutdowns.

All serial and load inputs pass through a two-flop synchronizer into the system clock domain. Edges are detected after synchronization. A word whose bit count is not exactly twelve is dropped.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset, all four output codes are 0x00 and no shutdown enable is set.
- R2: A word is shifted MSB first, one bit on each synchronized rising edge of `sclk`. Its layout is bit 11 all-off flag (active low), bit 10 channel-off flag (active low), bits 9:8 channel address, bits 7:0 data byte. It takes effect on the rising edge of `cs_n`.
- R3: Address 00 selects channel 0, 01 channel 1, 10 channel 2 and 11 channel 3. Channel i appears on `dac_codes[8*i+7:8*i]` and on `shdn[i]`.
- R4: Serial clock edges while `cs_n` is high change nothing. A select pulse with no clock edges writes nothing.
- R5: A word with fewer or more than 12 clock edges between the fall and the rise of `cs_n` is discarded. No staging register and no shutdown flag changes.
- R6: While `ldac_n` is high, the output codes stay unchanged, even when new words are written.
- R7: While `ldac_n` is low, every output code follows its staging register, including words written during that time.
- R8: A word with bit 11 at 0 sets all four shutdown enables.
- R9: A word with bit 11 at 1 and bit 10 at 0 sets the shutdown enable of the addressed channel only.
- R10: A word with bits 11 and 10 both at 1 clears the shutdown enable of the addressed channel and leaves the other channels unchanged.
- R11: While `clr_n` is low, all staging registers, output codes and shutdown enables are zero, whatever the state of `ldac_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdin | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low word select; a rising edge commits the word |
| ldac_n | input | 1 | Active-low, level-sensitive load of all output codes |
| clr_n | input | 1 | Active-low asynchronous clear to zero scale |
| dac_codes | output | 32 | Four 8-bit output codes, channel 0 in the low byte |
| shdn | output | 4 | Per-channel shutdown enables, active high |

## Verification
Words are written with distinct, asymmetric data per channel, such as 0x80 against 0x01. A swapped address decode, a reversed bit order or a misplaced byte lane therefore shows up as a wrong byte. The same writes are made with the load input high and then low, which separates the buffered case from the case where the outputs follow the staging registers. Malformed traffic is sent next: words of 11 and 13 bits, clock edges while deselected, and an empty select pulse. These show whether the bit count is enforced and the commit strobe is properly gated. Finally, the three shutdown encodings are applied in turn, followed by a clear with the load input held low. Together they tell the global, single-channel and release shutdown paths apart and show that clear wins over load.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CH        = 4;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = $clog2(CH);
  localparam int unsigned WORD_BITS = 2 + AW + DW;

  typedef struct packed {
    logic          all_on;   // low: every channel shuts down
    logic          one_on;   // low: addressed channel shuts down
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } cmd_t;

  function automatic cmd_t unpack_word(input logic [WORD_BITS-1:0] w);
    return cmd_t'(w);
  endfunction

  function automatic logic [CH-1:0] next_shdn(input logic [CH-1:0] cur, input cmd_t c);
    logic [CH-1:0] n;
    n = cur;
    if (!c.all_on)      n = '1;
    else if (!c.one_on) n[c.addr] = 1'b1;
    else                n[c.addr] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned   W    = 1,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
  import qdac_pkg::*;
#(
  parameter int unsigned NBITS = WORD_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             sdin_s,
  output logic [NBITS-1:0] word,
  output logic             commit
);
  localparam int unsigned CW = $clog2(NBITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(NBITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(NBITS + 1);

  logic          sclk_d, cs_d;
  logic [CW-1:0] count;
  logic          sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign commit    = cs_rise && (count == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      count  <= '0;
      word   <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      if (cs_n_s) begin
        count <= '0;
      end else if (sclk_rise) begin
        word <= {word[NBITS-2:0], sdin_s};
        if (count != CNT_OVER) count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             commit,
  input  cmd_t             cmd,
  input  logic             ld_n_s,
  output logic [CH*DW-1:0] in_flat,
  output logic [CH*DW-1:0] dac_flat,
  output logic [CH-1:0]    shdn
);
  logic bank_rst_n;
  assign bank_rst_n = rst_n & clr_n;

  for (genvar ch = 0; ch < CH; ch++) begin : g_ch
    logic [DW-1:0] stage_r, out_r;

    always_ff @(posedge clk or negedge bank_rst_n) begin
      if (!bank_rst_n)                         stage_r <= '0;
      else if (commit && cmd.addr == AW'(ch))  stage_r <= cmd.data;
    end

    always_ff @(posedge clk or negedge bank_rst_n) begin
      if (!bank_rst_n)  out_r <= '0;
      else if (!ld_n_s) out_r <= stage_r;
    end

    assign in_flat[ch*DW +: DW]  = stage_r;
    assign dac_flat[ch*DW +: DW] = out_r;
  end

  always_ff @(posedge clk or negedge bank_rst_n) begin
    if (!bank_rst_n)  shdn <= '0;
    else if (commit)  shdn <= next_shdn(shdn, cmd);
  end
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdin,
  input  logic             cs_n,
  input  logic             ldac_n,
  input  logic             clr_n,
  output logic [CH*DW-1:0] dac_codes,
  output logic [CH-1:0]    shdn
);
  logic [3:0]           raw_in, syn_out;
  logic                 sclk_s, cs_n_s, sdin_s, ld_n_s;
  logic [WORD_BITS-1:0] word;
  logic                 word_commit;
  cmd_t                 cmd;
  logic                 word_all_on;
  logic [CH*DW-1:0]     in_flat;

  assign raw_in = {ldac_n, sclk, cs_n, sdin};
  assign {ld_n_s, sclk_s, cs_n_s, sdin_s} = syn_out;

  qdac_sync #(.W(4), .INIT(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
  );

  qdac_shift #(.NBITS(WORD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
    .sdin_s(sdin_s), .word(word), .commit(word_commit)
  );

  assign cmd         = unpack_word(word);
  assign word_all_on = cmd.all_on;

  qdac_bank u_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .commit(word_commit),
    .cmd(cmd), .ld_n_s(ld_n_s), .in_flat(in_flat),
    .dac_flat(dac_codes), .shdn(shdn)
  );
endmodule

// File: rtl/qdac_serial_ctrl_chk.sv
module qdac_serial_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_n,
  input logic           ld_n_s,
  input logic           word_commit,
  input logic           word_all_on,
  input logic [CW-1:0]  in_flat,
  input logic [CW-1:0]  dac_codes,
  input logic [NCH-1:0] shdn
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_codes == '0 && in_flat == '0 && shdn == '0)); // R11

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    ($past(ld_n_s) && $past(clr_n)) |-> $stable(dac_codes)); // R6

  AST_FOLLOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !ld_n_s |=> (dac_codes == $past(in_flat))); // R7

  AST_ALL_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (word_commit && !word_all_on) |=> (shdn == '1)); // R8

  AST_NO_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !word_commit |=> ($stable(in_flat) && $stable(shdn))); // R5
endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(.NCH(qdac_pkg::CH), .CW(qdac_pkg::CH * qdac_pkg::DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n_s(ld_n_s),
  .word_commit(word_commit), .word_all_on(word_all_on),
  .in_flat(in_flat), .dac_codes(dac_codes), .shdn(shdn)
);

// File: tb/tb_qdac_serial_ctrl.sv
`timescale 1ns/1ps
module tb_qdac_serial_ctrl;
  logic clk = 1'b0;
  logic rst_n, sclk, sdin, cs_n, ldac_n, clr_n;
  logic [31:0] dac_codes;
  logic [3:0]  shdn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] m_in [4];
  logic [7:0] m_out [4];
  logic [3:0] m_sd;
  bit         m_ld;

  logic [35:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  qdac_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_codes(dac_codes), .shdn(shdn)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_q.push_back({m_out[3], m_out[2], m_out[1], m_out[0], m_sd});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  // monitor: compares the current outputs against each pushed item
  initial begin
    forever begin
      logic [35:0] e;
      string t;
      wait (exp_q.size() > 0);
      e = exp_q[0];
      t = tag_q[0];
      checks++;
      if ({dac_codes, shdn} !== e) begin
        failures++;
        $display("FAIL %s: actual codes=%h shdn=%b expected codes=%h shdn=%b",
                 t, dac_codes, shdn, e[35:4], e[3:0]);
      end
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic send_bits(input logic [15:0] bits, input int n);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = bits[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic send_word(input bit all_on, input bit one_on, input logic [1:0] a, input logic [7:0] d);
    send_bits({4'h0, all_on, one_on, a, d}, 12);
    m_in[a] = d;
    if (!all_on)      m_sd = 4'hF;
    else if (!one_on) m_sd[a] = 1'b1;
    else              m_sd[a] = 1'b0;
    if (m_ld) for (int k = 0; k < 4; k++) m_out[k] = m_in[k];
  endtask

  task automatic set_load(input bit active);
    ldac_n = ~active;
    m_ld = active;
    wait_clk(6);
    if (active) for (int k = 0; k < 4; k++) m_out[k] = m_in[k];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; cs_n = 1'b1; ldac_n = 1'b1; clr_n = 1'b1;
    for (int k = 0; k < 4; k++) begin m_in[k] = 8'h00; m_out[k] = 8'h00; end
    m_sd = 4'h0; m_ld = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    expect_now("R1 reset zero state");

    send_word(1, 1, 2'b00, 8'h11);
    expect_now("R6 R2 buffered write ch0, load high");
    send_word(1, 1, 2'b01, 8'h22);
    send_word(1, 1, 2'b10, 8'h33);
    send_word(1, 1, 2'b11, 8'hC4);
    expect_now("R6 four channels preloaded, outputs held");

    set_load(1);
    expect_now("R7 R3 load copies all channels to their lanes");
    send_word(1, 1, 2'b00, 8'h5A);
    expect_now("R7 write passes through while load low");

    set_load(0);
    send_word(1, 1, 2'b00, 8'hA5);
    expect_now("R6 load released, output holds old ch0");
    set_load(1);
    expect_now("R7 reload picks up ch0");

    send_bits({5'h0, 1'b1, 1'b1, 2'b01, 8'hFF}, 11);
    expect_now("R5 11-bit word discarded");
    send_bits({3'h0, 1'b1, 1'b1, 1'b1, 2'b01, 8'hFF}, 13);
    expect_now("R5 13-bit word discarded");

    for (int i = 0; i < 12; i++) begin
      sdin = i[0];
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    send_bits(16'h0000, 0);
    expect_now("R4 clocks with select high ignored");

    send_word(1, 0, 2'b01, 8'h40);
    expect_now("R9 single-channel shutdown ch1");
    send_word(0, 1, 2'b00, 8'h01);
    expect_now("R8 all-channel shutdown");
    send_word(1, 1, 2'b10, 8'h77);
    expect_now("R10 release ch2 only");

    clr_n = 1'b0;
    for (int k = 0; k < 4; k++) begin m_in[k] = 8'h00; m_out[k] = 8'h00; end
    m_sd = 4'h0;
    wait_clk(3);
    expect_now("R11 clear wins over active load");
    clr_n = 1'b1;
    wait_clk(4);
    expect_now("R11 zero after clear release");

    send_word(1, 1, 2'b11, 8'h80);
    expect_now("R2 R3 MSB-first data on ch3 lane");
    send_word(1, 1, 2'b01, 8'h01);
    expect_now("R2 R3 LSB data on ch1 lane");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule